// File: doc/BRIEF.md
# Serial Response Frame Checker

This block takes a response frame from a serial link one bit at a time and works out what the far end answered. A frame has three parts. A 4-bit tag comes first and carries the 2-bit response code in its low bits. An optional data field follows. A 4-bit check code closes the frame. The requester pulses `start` when a response is due and gives the byte size it asked for. From then on, every cycle with `bit_en` high delivers one line bit, most significant bit first.

When the last check bit arrives, the block does four things. It validates a 4-bit cyclic code over the whole frame. It reports the response code and the right-justified data. It flags a frame that is all ones or all zeros as a device that is not there, rather than as a retryable check error. It then gives a one-cycle `done`. The results stay on the outputs until the next `done`.

Top module: `rfc_resp_check`

## Requirements
- R1: After a synchronous active-low reset, `done`, `resp_code`, `rx_data`, `crc_ok` and `dev_absent` are all zero.
- R2: After `start`, the first four accepted bits form the tag, most significant bit first. `resp_code` is the tag's low two bits, with acknowledge=0, busy=1, error-A=2 and error-C=3.
- R3: The data length is taken from `len_sel` in the `start` cycle and held for the whole frame: 0 gives no data, 1 gives 8 bits, 2 gives 16 bits and 3 gives 32 bits. A data field follows the tag only when the code is acknowledge and the length is nonzero. Otherwise the four check bits follow the tag directly.
- R4: `rx_data` holds the data field right-justified, with the upper bits zero. It is all zero when the frame had no data field.
- R5: The check runs a serial cyclic code with polynomial x^4+x^2+x+1 and an initial value of zero. It covers a leading 1 bit, the tag bits, any data bits and the four received check bits, in that order. `crc_ok` is 1 exactly when the final remainder is zero.
- R6: `dev_absent` is 1 when the check fails and the tag and received check field are either both 0xF or both 0x0. It is never 1 together with `crc_ok`.
- R7: `done` is a one-cycle pulse in the cycle after the last check bit is accepted. The other outputs change only alongside `done` and hold their values between pulses.
- R8: Cycles with `bit_en` low pause the frame without loss. Bits offered while no frame is open are ignored.
- R9: A `start` in the middle of a frame abandons that frame without a `done` and opens a new one. A bit offered in the same cycle as `start` is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Opens a new frame and latches the length |
| len_sel | input | 2 | Requested data length code |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial line bit, MSB first |
| done | output | 1 | One-cycle pulse when results are ready |
| resp_code | output | 2 | Response code from the tag |
| rx_data | output | 32 | Right-justified received data |
| crc_ok | output | 1 | Frame check passed |
| dev_absent | output | 1 | All-ones or all-zeros frame with a failed check |

## Verification
The hardest case to reach is the missing-device report. It needs a failing check together with tag and check fields that are both 0xF or both 0x0. The all-zeros form also passes through a full acknowledge data field, because a zero tag decodes as acknowledge. The bench builds these frames on purpose: it sends an all-ones frame, and an all-zeros frame with a 16-bit request. Next to them it sends a near miss, a corrupted frame whose fields are not uniform, which must show a plain check error. Abort and same-cycle start/bit collisions are driven explicitly, and `bit_en` gaps are inserted between bits.

// File: rtl/rfc_pkg.sv
// Package rfc_pkg
// Shared types for the serial response frame checker: the response codes
// carried in the low tag bits and the capture phases of the controller.
package rfc_pkg;

    typedef enum logic [1:0] {
        RSP_ACK  = 2'd0,
        RSP_BUSY = 2'd1,
        RSP_ERRA = 2'd2,
        RSP_ERRC = 2'd3
    } rsp_code_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_TAG  = 2'd1,
        PH_DATA = 2'd2,
        PH_CHK  = 2'd3
    } phase_e;

endpackage

// File: rtl/rfc_shift_cap.sv
// Module rfc_shift_cap
// Left-shifting capture register. A clear empties it; each shift moves in
// one serial bit at the LSB, so a partial fill stays right-justified.
// Assumes clear and shift are never needed together (clear wins).
module rfc_shift_cap #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift,
    input  logic         bit_in,
    output logic [W-1:0] value_q
);

    // Capture register update: clear, then shift-in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (clear) begin
            value_q <= '0;
        end else if (shift) begin
            value_q <= {value_q[W-2:0], bit_in};
        end
    end

endmodule

// File: rtl/rfc_crc_serial.sv
// Module rfc_crc_serial
// Bit-serial cyclic code register, MSB-first, no output inversion.
// init loads the state reached by feeding a single 1 into a zero register,
// which is POLY itself, so the frame's leading 1 costs no extra cycle.
// rem_next shows the value after this cycle's step (or the held value).
module rfc_crc_serial #(
    parameter int           W    = 4,
    parameter logic [W-1:0] POLY = 4'h7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic         step,
    input  logic         bit_in,
    output logic [W-1:0] rem_next
);

    localparam logic [W-1:0] SEED = POLY;

    logic [W-1:0] rem_q;
    logic         feedback;

    // One LFSR step on the incoming bit.
    always_comb begin
        feedback = rem_q[W-1] ^ bit_in;
        rem_next = rem_q;
        if (step) begin
            rem_next = {rem_q[W-2:0], 1'b0} ^ (feedback ? POLY : '0);
        end
    end

    // Remainder register: seed on init, advance on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (init) begin
            rem_q <= SEED;
        end else begin
            rem_q <= rem_next;
        end
    end

endmodule

// File: rtl/rfc_ctrl.sv
// Module rfc_ctrl
// Frame sequencer. Walks tag -> optional data -> check field, counting
// accepted bits, and says which capture register takes each bit.
// Assumes DATA_W is a multiple of 4 and no smaller than TAG_W and CHK_W.
// start preempts any frame in progress; the start cycle's bit is not taken.
module rfc_ctrl
    import rfc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4,
    parameter int CHK_W  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] len_sel,
    input  logic       bit_en,
    input  logic [1:0] code_next,
    output logic       take,
    output logic       tag_shift,
    output logic       data_shift,
    output logic       chk_shift,
    output logic       finish
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_q;

    // Map the request length code to a bit count.
    function automatic logic [CNT_W-1:0] len_bits(input logic [1:0] sel);
        logic [CNT_W-1:0] r;
        r = '0;
        if (sel != 2'd0) begin
            r = CNT_W'(DATA_W >> (3 - int'(sel)));
        end
        return r;
    endfunction

    // Per-cycle strobes for the datapath.
    always_comb begin
        take       = bit_en && !start && (phase_q != PH_IDLE);
        tag_shift  = take && (phase_q == PH_TAG);
        data_shift = take && (phase_q == PH_DATA);
        chk_shift  = take && (phase_q == PH_CHK);
        finish     = chk_shift && (cnt_q == '0);
    end

    // Phase and bit counter sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            len_q   <= '0;
        end else if (start) begin
            phase_q <= PH_TAG;
            cnt_q   <= CNT_W'(TAG_W - 1);
            len_q   <= len_bits(len_sel);
        end else if (take) begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end else begin
                unique case (phase_q)
                    PH_TAG: begin
                        if (code_next == RSP_ACK && len_q != '0) begin
                            phase_q <= PH_DATA;
                            cnt_q   <= len_q - CNT_W'(1);
                        end else begin
                            phase_q <= PH_CHK;
                            cnt_q   <= CNT_W'(CHK_W - 1);
                        end
                    end
                    PH_DATA: begin
                        phase_q <= PH_CHK;
                        cnt_q   <= CNT_W'(CHK_W - 1);
                    end
                    default: begin
                        phase_q <= PH_IDLE;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/rfc_resp_check.sv
// Module rfc_resp_check
// Serial response frame checker top. Captures tag, optional data and check
// field, runs the serial cyclic code across the frame, and registers the
// classification with a one-cycle done. Outputs hold between done pulses.
// Assumes bits arrive MSB first, qualified by bit_en, after a start pulse.
module rfc_resp_check
    import rfc_pkg::*;
#(
    parameter int              DATA_W   = 32,
    parameter int              TAG_W    = 4,
    parameter int              CHK_W    = 4,
    parameter logic [CHK_W-1:0] CHK_POLY = 4'h7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        len_sel,
    input  logic              bit_en,
    input  logic              bit_in,
    output logic              done,
    output logic [1:0]        resp_code,
    output logic [DATA_W-1:0] rx_data,
    output logic              crc_ok,
    output logic              dev_absent
);

    logic              take;
    logic              tag_shift;
    logic              data_shift;
    logic              chk_shift;
    logic              finish;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] data_q;
    logic [CHK_W-1:0]  chk_q;
    logic [CHK_W-1:0]  rem_next;
    logic [CHK_W-1:0]  chk_full;
    logic [1:0]        code_next;
    logic              uniform;

    rfc_ctrl #(
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W),
        .CHK_W  (CHK_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .len_sel    (len_sel),
        .bit_en     (bit_en),
        .code_next  (code_next),
        .take       (take),
        .tag_shift  (tag_shift),
        .data_shift (data_shift),
        .chk_shift  (chk_shift),
        .finish     (finish)
    );

    rfc_shift_cap #(.W(TAG_W)) u_tag (
        .clk (clk), .rst_n (rst_n), .clear (start),
        .shift (tag_shift), .bit_in (bit_in), .value_q (tag_q)
    );

    rfc_shift_cap #(.W(DATA_W)) u_data (
        .clk (clk), .rst_n (rst_n), .clear (start),
        .shift (data_shift), .bit_in (bit_in), .value_q (data_q)
    );

    rfc_shift_cap #(.W(CHK_W)) u_chk (
        .clk (clk), .rst_n (rst_n), .clear (start),
        .shift (chk_shift), .bit_in (bit_in), .value_q (chk_q)
    );

    rfc_crc_serial #(.W(CHK_W), .POLY(CHK_POLY)) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (start),
        .step     (take),
        .bit_in   (bit_in),
        .rem_next (rem_next)
    );

    // Lookahead values including the bit accepted this cycle.
    always_comb begin
        code_next = {tag_q[0], bit_in};
        chk_full  = {chk_q[CHK_W-2:0], bit_in};
        uniform   = ((&tag_q) && (&chk_full)) || ((tag_q == '0) && (chk_full == '0));
    end

    // Result registers, loaded only when the final check bit lands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            resp_code  <= 2'b00;
            rx_data    <= '0;
            crc_ok     <= 1'b0;
            dev_absent <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                resp_code  <= tag_q[1:0];
                rx_data    <= data_q;
                crc_ok     <= (rem_next == '0);
                dev_absent <= (rem_next != '0) && uniform;
            end
        end
    end

endmodule

// File: rtl/rfc_resp_check_sva.sv
// Module rfc_resp_check_sva
// Property checker for rfc_resp_check, attached by bind below.
module rfc_resp_check_sva #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              bit_en,
    input logic              done,
    input logic [1:0]        resp_code,
    input logic [DATA_W-1:0] rx_data,
    input logic              crc_ok,
    input logic              dev_absent
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(rx_data) && $stable(resp_code) && $stable(crc_ok) && $stable(dev_absent))); // R7

    AST_ABSENT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        dev_absent |-> !crc_ok); // R6

    AST_NO_DATA_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (done && resp_code != 2'd0) |-> (rx_data == '0)); // R4

    AST_DONE_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bit_en)); // R8

    AST_START_NO_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done); // R9

endmodule

bind rfc_resp_check rfc_resp_check_sva #(.DATA_W(DATA_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .bit_en     (bit_en),
    .done       (done),
    .resp_code  (resp_code),
    .rx_data    (rx_data),
    .crc_ok     (crc_ok),
    .dev_absent (dev_absent)
);

// File: tb/rfc_resp_check_test.sv
module rfc_resp_check_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  len_sel = 2'd0;
    logic        bit_en = 1'b0;
    logic        bit_in = 1'b0;
    logic        done;
    logic [1:0]  resp_code;
    logic [31:0] rx_data;
    logic        crc_ok;
    logic        dev_absent;

    int   n_run  = 0;
    int   n_fail = 0;
    logic drv_last = 1'b0;
    logic mon_on   = 1'b0;

    logic [1:0]  exp_code = '0;
    logic [31:0] exp_data = '0;
    logic        exp_ok   = 1'b0;
    logic        exp_abs  = 1'b0;

    always #5 clk = ~clk;

    rfc_resp_check uut (
        .clk (clk), .rst_n (rst_n), .start (start), .len_sel (len_sel),
        .bit_en (bit_en), .bit_in (bit_in), .done (done),
        .resp_code (resp_code), .rx_data (rx_data), .crc_ok (crc_ok),
        .dev_absent (dev_absent)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Per-clock model of done: high exactly after the last check bit is taken (R7).
    always @(posedge clk) begin
        logic e;
        logic on;
        e  = drv_last;
        on = mon_on;
        #2;
        if (on) check("R7", "done timing", {31'd0, done}, {31'd0, e});
    end

    // Reference cyclic code, polynomial x^4+x^2+x+1 (R5).
    function automatic logic [3:0] crc_feed(input logic [3:0] c, input logic [63:0] v, input int n);
        logic [3:0] r;
        r = c;
        for (int i = n - 1; i >= 0; i--) begin
            logic fb;
            fb = r[3] ^ v[i];
            r  = {r[2:0], 1'b0} ^ (fb ? 4'h7 : 4'h0);
        end
        return r;
    endfunction

    // mode: 0 = correct check field, 1 = corrupted, 2 = forced value.
    task automatic send(input logic [3:0] tag, input logic [31:0] data, input logic [1:0] lsel,
                        input int mode, input logic [3:0] forced, input bit gaps, input bit start_bit);
        logic q[$];
        int          nd;
        logic [3:0]  c;
        logic [3:0]  cf;
        logic [3:0]  rem;
        nd = (tag[1:0] == 2'd0 && lsel != 2'd0) ? (4 << lsel) : 0;
        c  = crc_feed(4'h0, 64'd1, 1);
        c  = crc_feed(c, {60'd0, tag}, 4);
        c  = crc_feed(c, {32'd0, data}, nd);
        cf = (mode == 0) ? c : (mode == 1) ? (c ^ 4'h2) : forced;
        rem = crc_feed(c, {60'd0, cf}, 4);
        exp_code = tag[1:0];
        exp_data = (nd == 0) ? 32'd0 : (nd == 32) ? data : (data & ((32'd1 << nd) - 1));
        exp_ok   = (rem == 4'h0);
        exp_abs  = !exp_ok && ((tag == 4'hF && cf == 4'hF) || (tag == 4'h0 && cf == 4'h0));
        for (int i = 3; i >= 0; i--) q.push_back(tag[i]);
        for (int i = nd - 1; i >= 0; i--) q.push_back(data[i]);
        for (int i = 3; i >= 0; i--) q.push_back(cf[i]);
        @(negedge clk);
        start = 1'b1; len_sel = lsel; bit_en = start_bit; bit_in = 1'b1;
        @(negedge clk);
        start = 1'b0; len_sel = ~lsel;
        for (int i = 0; i < q.size(); i++) begin
            if (gaps && (i % 3 == 1)) begin
                bit_en = 1'b0; bit_in = ~q[i];
                @(negedge clk);
            end
            bit_en = 1'b1; bit_in = q[i]; drv_last = (i == q.size() - 1);
            if (i == q.size() - 1) begin
                @(posedge clk); #2;
                check("R2", "resp_code", {30'd0, resp_code}, {30'd0, exp_code});
                check("R4", "rx_data", rx_data, exp_data);
                check("R5", "crc_ok", {31'd0, crc_ok}, {31'd0, exp_ok});
                check("R6", "dev_absent", {31'd0, dev_absent}, {31'd0, exp_abs});
            end
            @(negedge clk);
        end
        bit_en = 1'b0; drv_last = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", "reset done", {31'd0, done}, 32'd0);
        check("R1", "reset code", {30'd0, resp_code}, 32'd0);
        check("R1", "reset data", rx_data, 32'd0);
        check("R1", "reset ok/abs", {30'd0, crc_ok, dev_absent}, 32'd0);
        mon_on = 1'b1;

        send(4'h0, 32'h0000_00A5, 2'd1, 0, 4'h0, 1'b0, 1'b0);   // R3 8-bit ack
        send(4'h4, 32'h0000_BEEF, 2'd2, 0, 4'h0, 1'b1, 1'b0);   // R3 16-bit ack, gaps R8
        send(4'h8, 32'hDEAD_C0DE, 2'd3, 0, 4'h0, 1'b1, 1'b0);   // R3 32-bit ack
        send(4'hC, 32'hFFFF_FFFF, 2'd0, 0, 4'h0, 1'b0, 1'b0);   // R3 ack, no data
        send(4'h1, 32'h1234_5678, 2'd3, 0, 4'h0, 1'b0, 1'b0);   // R3 busy, no data
        send(4'h2, 32'h1234_5678, 2'd2, 0, 4'h0, 1'b1, 1'b0);   // R2 error-A
        send(4'h7, 32'h1234_5678, 2'd1, 0, 4'h0, 1'b0, 1'b0);   // R2 error-C
        send(4'h0, 32'h0000_3C3C, 2'd2, 1, 4'h0, 1'b0, 1'b0);   // R5 bad check
        send(4'hF, 32'h0, 2'd3, 2, 4'hF, 1'b0, 1'b0);           // R6 all ones
        send(4'h0, 32'h0, 2'd2, 2, 4'h0, 1'b0, 1'b0);           // R6 all zeros with data
        send(4'hB, 32'h0, 2'd1, 1, 4'h0, 1'b0, 1'b0);           // R6 near miss

        // R8: bits with no frame open are ignored and outputs hold.
        @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            bit_en = 1'b1; bit_in = i[0];
            @(negedge clk);
        end
        bit_en = 1'b0;
        check("R8", "idle data hold", rx_data, exp_data);
        check("R8", "idle flags hold", {29'd0, resp_code, dev_absent}, {29'd0, exp_code, exp_abs});

        // R9: abandon a frame after three tag bits, then run a fresh one.
        @(negedge clk);
        start = 1'b1; len_sel = 2'd3;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            bit_en = 1'b1; bit_in = 1'b1;
            @(negedge clk);
        end
        bit_en = 1'b0;
        send(4'h0, 32'h0000_005A, 2'd1, 0, 4'h0, 1'b0, 1'b0);   // R9 restart
        send(4'h4, 32'h0000_9669, 2'd2, 0, 4'h0, 1'b1, 1'b1);   // R9 start-cycle bit dropped

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule